// File: doc/BRIEF.md
# Serial Programming Command Port

This block is the slave end of a four-wire programming link: a serial clock, a data input, a data output and a hold line that keeps the rest of the device in reset. While the hold line is low, the host shifts four-byte instructions in. The block decodes them and acts on two byte-wide memories that sit inside the block: a program store and a data store. Every instruction is exactly four bytes long. Read results return in the last byte. Each earlier byte is echoed one byte later, so the host can tell whether it is still aligned with the byte boundaries.

The block does nothing until the host sends the enable key. After that it accepts chip erase and byte reads and writes to both memories. A write to the data store starts a timed window. During that window a read of the same address returns two placeholder values in turn, so the host can poll for completion instead of waiting a fixed time. The serial clock is sampled with the system clock. The host therefore has to hold each clock level for several system cycles.

Top module: `prog_serial_if`

## Requirements
- R1: After reset `miso` is 0, programming is not enabled, and every byte of both memories reads 0xFF.
- R2: Bits move most significant bit first. `mosi` is captured on a rising edge of `sck`. `miso` changes only after a falling edge of `sck`, or when it is forced low by the hold line. The first byte of every instruction returns 0x00.
- R3: Only the instruction 0xAC, 0x53, any, any, sent while `prog_hold_n` is low, enables programming. Until then every other instruction leaves both memories unchanged, and a read returns its third byte.
- R4: During the second, third and fourth bytes, `miso` carries the first, second and third received bytes. The one exception is the fourth byte of an enabled read.
- R5: The program read 0x20, hi, lo, any returns the program byte at {hi,lo} modulo the program depth in its fourth byte.
- R6: The program write 0x40, hi, lo, d stores d at {hi,lo} modulo the program depth once the fourth byte completes.
- R7: The data write 0xC0, hi, lo, d stores d. The data read 0xA0, hi, lo, any returns the stored byte once the write window has ended.
- R8: For ERASE_CYC cycles after a data write, a read of that address returns 0x80. For the next PROG_CYC cycles it returns 0x7F. Reads of other addresses are not affected.
- R9: The erase instruction 0xAC followed by a byte whose top three bits are 100 sets every byte of both memories to 0xFF and ends any write window.
- R10: While `prog_hold_n` is high, `miso` is 0, bit and byte positions return to the start, programming enable is cleared, and instructions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_hold_n | input | 1 | Low holds the device in reset and opens the programming link |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The assertions assume that `sck` stays at each level for several system clocks. Under that assumption, one rising edge, its captured byte and the load of the next output byte finish before the following falling edge. The bench holds each `sck` level for eight system cycles and changes `mosi` only while `sck` is low. The polling windows in the bench are set far longer than any uncertainty in the moment of capture, so every expected placeholder falls well inside its phase.

// File: rtl/prog_serial_pkg.sv
package prog_serial_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t KEY_LEAD    = 8'hAC;
    localparam byte_t KEY_ENABLE  = 8'h53;
    localparam logic [2:0] ERASE_TAG = 3'b100;
    localparam byte_t OPC_RD_PGM  = 8'h20;
    localparam byte_t OPC_WR_PGM  = 8'h40;
    localparam byte_t OPC_RD_DAT  = 8'hA0;
    localparam byte_t OPC_WR_DAT  = 8'hC0;
    localparam byte_t POLL_ERASE  = 8'h80;
    localparam byte_t POLL_PROG   = 8'h7F;
    localparam byte_t BLANK       = 8'hFF;
    localparam int    ADDR_W      = 16;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ENABLE,
        OP_ERASE,
        OP_RD_PGM,
        OP_WR_PGM,
        OP_RD_DAT,
        OP_WR_DAT
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ERASE,
        PH_PROG
    } phase_e;

    typedef struct packed {
        logic              erase;
        logic              wr_pgm;
        logic              wr_dat;
        logic [ADDR_W-1:0] addr;
        byte_t             data;
    } mem_cmd_t;

    function automatic op_e decode_op(input byte_t first, input byte_t second);
        op_e r;
        r = OP_NONE;
        if (first == KEY_LEAD) begin
            if (second == KEY_ENABLE)
                r = OP_ENABLE;
            else if (second[7:5] == ERASE_TAG)
                r = OP_ERASE;
        end else if (first == OPC_RD_PGM) begin
            r = OP_RD_PGM;
        end else if (first == OPC_WR_PGM) begin
            r = OP_WR_PGM;
        end else if (first == OPC_RD_DAT) begin
            r = OP_RD_DAT;
        end else if (first == OPC_WR_DAT) begin
            r = OP_WR_DAT;
        end
        return r;
    endfunction

endpackage

// File: rtl/psi_shifter.sv
module psi_shifter
    import prog_serial_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  logic        sck,
    input  logic        mosi,
    input  logic        load_vld,
    input  byte_t       load_byte,
    output logic        miso,
    output logic        byte_vld,
    output byte_t       byte_val
);

    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);

    logic             sck_q;
    logic [CNT_W-1:0] bit_cnt;
    byte_t            rx_q;
    byte_t            tx_q;
    logic             rise;
    logic             fall;

    assign rise = active & sck & ~sck_q;
    assign fall = active & sck_q & ~sck;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            bit_cnt  <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            miso     <= 1'b0;
            byte_vld <= 1'b0;
            byte_val <= '0;
        end else begin
            sck_q    <= sck;
            byte_vld <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
                rx_q    <= '0;
                tx_q    <= '0;
                miso    <= 1'b0;
            end else begin
                if (rise) begin
                    rx_q    <= {rx_q[6:0], mosi};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        byte_vld <= 1'b1;
                        byte_val <= {rx_q[6:0], mosi};
                    end
                end
                if (load_vld) begin
                    tx_q <= load_byte;
                end else if (fall) begin
                    miso <= tx_q[7];
                    tx_q <= {tx_q[6:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/psi_decoder.sv
module psi_decoder
    import prog_serial_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              byte_vld,
    input  byte_t             byte_val,
    input  byte_t             pgm_rdata,
    input  byte_t             dat_rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              load_vld,
    output byte_t             load_byte,
    output mem_cmd_t          cmd,
    output logic              enabled
);

    logic [1:0] idx_q;
    byte_t      b1_q;
    byte_t      b2_q;
    byte_t      b3_q;
    op_e        op;

    assign op       = decode_op(b1_q, b2_q);
    assign rd_addr  = {b2_q, byte_val};
    assign load_vld = byte_vld;

    always_comb begin
        load_byte = byte_val;
        case (idx_q)
            2'd2: begin
                if (enabled && op == OP_RD_PGM)
                    load_byte = pgm_rdata;
                else if (enabled && op == OP_RD_DAT)
                    load_byte = dat_rdata;
            end
            2'd3: load_byte = '0;
            default: load_byte = byte_val;
        endcase
    end

    always_comb begin
        cmd      = '0;
        cmd.addr = {b2_q, b3_q};
        cmd.data = byte_val;
        if (byte_vld && idx_q == 2'd3 && enabled) begin
            cmd.erase  = (op == OP_ERASE);
            cmd.wr_pgm = (op == OP_WR_PGM);
            cmd.wr_dat = (op == OP_WR_DAT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            b1_q    <= '0;
            b2_q    <= '0;
            b3_q    <= '0;
            enabled <= 1'b0;
        end else if (!active) begin
            idx_q   <= '0;
            enabled <= 1'b0;
        end else if (byte_vld) begin
            idx_q <= idx_q + 1'b1;
            case (idx_q)
                2'd0: b1_q <= byte_val;
                2'd1: b2_q <= byte_val;
                2'd2: b3_q <= byte_val;
                default: begin
                    if (op == OP_ENABLE)
                        enabled <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/psi_mem.sv
module psi_mem
    import prog_serial_pkg::*;
#(
    parameter int PGM_DEPTH = 64,
    parameter int DAT_DEPTH = 32,
    parameter int ERASE_CYC = 400,
    parameter int PROG_CYC  = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  mem_cmd_t          cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    output byte_t             pgm_rdata,
    output byte_t             dat_rdata,
    output phase_e            phase
);

    localparam int PAW  = $clog2(PGM_DEPTH);
    localparam int DAW  = $clog2(DAT_DEPTH);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    byte_t            pmem [PGM_DEPTH];
    byte_t            dmem [DAT_DEPTH];
    logic [DAW-1:0]   busy_addr;
    logic [CW-1:0]    cnt;
    logic [PAW-1:0]   wr_pa;
    logic [DAW-1:0]   wr_da;
    logic [PAW-1:0]   rd_pa;
    logic [DAW-1:0]   rd_da;

    assign wr_pa = PAW'(cmd.addr % PGM_DEPTH);
    assign wr_da = DAW'(cmd.addr % DAT_DEPTH);
    assign rd_pa = PAW'(rd_addr % PGM_DEPTH);
    assign rd_da = DAW'(rd_addr % DAT_DEPTH);

    assign pgm_rdata = pmem[rd_pa];

    always_comb begin
        dat_rdata = dmem[rd_da];
        if (phase != PH_IDLE && rd_da == busy_addr)
            dat_rdata = (phase == PH_ERASE) ? POLL_ERASE : POLL_PROG;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.erase) begin
            for (int i = 0; i < PGM_DEPTH; i++) pmem[i] <= BLANK;
            for (int i = 0; i < DAT_DEPTH; i++) dmem[i] <= BLANK;
        end else begin
            if (cmd.wr_pgm) pmem[wr_pa] <= cmd.data;
            if (cmd.wr_dat) dmem[wr_da] <= cmd.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.erase) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            busy_addr <= '0;
        end else if (cmd.wr_dat) begin
            phase     <= PH_ERASE;
            cnt       <= '0;
            busy_addr <= wr_da;
        end else begin
            case (phase)
                PH_ERASE: begin
                    if (cnt == CW'(ERASE_CYC - 1)) begin
                        phase <= PH_PROG;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PROG: begin
                    if (cnt == CW'(PROG_CYC - 1)) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/prog_serial_if.sv
module prog_serial_if
    import prog_serial_pkg::*;
#(
    parameter int PGM_DEPTH = 64,
    parameter int DAT_DEPTH = 32,
    parameter int ERASE_CYC = 400,
    parameter int PROG_CYC  = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_hold_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);

    logic              active;
    logic              byte_vld;
    byte_t             byte_val;
    logic              load_vld;
    byte_t             load_byte;
    logic [ADDR_W-1:0] rd_addr;
    byte_t             pgm_rdata;
    byte_t             dat_rdata;
    mem_cmd_t          cmd;
    logic              enabled;
    phase_e            phase;
    logic              erase_req;
    logic              dwr_req;

    assign active    = ~prog_hold_n;
    assign erase_req = cmd.erase;
    assign dwr_req   = cmd.wr_dat;

    psi_shifter #(.BITS(8)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .sck       (sck),
        .mosi      (mosi),
        .load_vld  (load_vld),
        .load_byte (load_byte),
        .miso      (miso),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val)
    );

    psi_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val),
        .pgm_rdata (pgm_rdata),
        .dat_rdata (dat_rdata),
        .rd_addr   (rd_addr),
        .load_vld  (load_vld),
        .load_byte (load_byte),
        .cmd       (cmd),
        .enabled   (enabled)
    );

    psi_mem #(
        .PGM_DEPTH (PGM_DEPTH),
        .DAT_DEPTH (DAT_DEPTH),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC)
    ) u_mem (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .rd_addr   (rd_addr),
        .pgm_rdata (pgm_rdata),
        .dat_rdata (dat_rdata),
        .phase     (phase)
    );

endmodule

// File: rtl/prog_serial_chk.sv
module prog_serial_chk
    import prog_serial_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   prog_hold_n,
    input logic   sck,
    input logic   miso,
    input logic   byte_vld,
    input logic   enabled,
    input phase_e phase,
    input logic   erase_req,
    input logic   dwr_req
);

    // R2
    miso_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(miso) |-> (($past(sck, 2) && !$past(sck)) || $past(prog_hold_n)));

    // R2
    byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        prog_hold_n |=> (miso == 1'b0 && !enabled));

    // R3
    enable_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(enabled) |-> ($past(byte_vld) && !$past(prog_hold_n)));

    // R8
    poll_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ERASE && $past(phase) == PH_PROG) |-> $past(dwr_req));

    // R8
    poll_order_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PROG) |-> ($past(phase) != PH_IDLE));

    // R9
    erase_ends_poll_chk: assert property (@(posedge clk) disable iff (rst)
        erase_req |=> (phase == PH_IDLE));

endmodule

bind prog_serial_if prog_serial_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .prog_hold_n (prog_hold_n),
    .sck         (sck),
    .miso        (miso),
    .byte_vld    (byte_vld),
    .enabled     (enabled),
    .phase       (phase),
    .erase_req   (erase_req),
    .dwr_req     (dwr_req)
);

// File: tb/sim_prog_serial_if.sv
module sim_prog_serial_if;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int PGM_D      = 64;
    localparam int DAT_D      = 32;
    localparam int ER_C       = 1000;
    localparam int PR_C       = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int pm [PGM_D];
    int dm [DAT_D];
    bit en = 1'b0;
    int wr_t = -1;
    int wr_a = 0;
    int t3 = 0;

    prog_serial_if #(
        .PGM_DEPTH (PGM_D),
        .DAT_DEPTH (DAT_D),
        .ERASE_CYC (ER_C),
        .PROG_CYC  (PR_C)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .prog_hold_n (hold_n),
        .sck         (sck),
        .mosi        (mosi),
        .miso        (miso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] w, output logic [31:0] rx);
        rx = '0;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            sck  = 1'b0;
            mosi = w[31-k];
            repeat (HALF) @(negedge clk);
            rx  = {rx[30:0], miso};
            sck = 1'b1;
            if (k == 23) t3 = cyc;
            repeat (HALF) @(negedge clk);
        end
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    function automatic int model_b4(input int b1, input int b2, input int b3);
        int a;
        a = (b2 * 256 + b3);
        if (en && b1 == 8'h20) return pm[a % PGM_D];
        if (en && b1 == 8'hA0) begin
            if (wr_t >= 0 && (a % DAT_D) == wr_a) begin
                if (t3 - wr_t < ER_C) return 8'h80;
                if (t3 - wr_t < ER_C + PR_C) return 8'h7F;
            end
            return dm[a % DAT_D];
        end
        return b3;
    endfunction

    task automatic model_exec(input int b1, input int b2, input int b3, input int b4);
        int a;
        a = b2 * 256 + b3;
        if (b1 == 8'hAC && b2 == 8'h53) en = 1'b1;
        else if (en) begin
            if (b1 == 8'hAC && (b2 >> 5) == 3'b100) begin
                foreach (pm[i]) pm[i] = 8'hFF;
                foreach (dm[i]) dm[i] = 8'hFF;
                wr_t = -1;
            end else if (b1 == 8'h40) begin
                pm[a % PGM_D] = b4;
            end else if (b1 == 8'hC0) begin
                dm[a % DAT_D] = b4;
                wr_t = cyc;
                wr_a = a % DAT_D;
            end
        end
    endtask

    task automatic instr(input logic [7:0] b1, input logic [7:0] b2,
                         input logic [7:0] b3, input logic [7:0] b4,
                         input string tag);
        logic [31:0] r;
        int e4;
        xfer({b1, b2, b3, b4}, r);
        if (hold_n) begin
            check({tag, " R10 idle byte1"}, r[31:24], 0);
            check({tag, " R10 idle byte2"}, r[23:16], 0);
            check({tag, " R10 idle byte3"}, r[15:8], 0);
            check({tag, " R10 idle byte4"}, r[7:0], 0);
        end else begin
            e4 = model_b4(b1, b2, b3);
            check({tag, " R2 first byte"}, r[31:24], 0);
            check({tag, " R4 echo byte2"}, r[23:16], b1);
            check({tag, " R4 echo byte3"}, r[15:8], b2);
            check({tag, " byte4"}, r[7:0], e4);
            model_exec(b1, b2, b3, b4);
        end
    endtask

    task automatic set_hold(input logic v);
        @(negedge clk);
        hold_n = v;
        if (v) en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        foreach (pm[i]) pm[i] = 8'hFF;
        foreach (dm[i]) dm[i] = 8'hFF;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 miso after reset", miso, 0);

        // R10: instructions sent with the hold line high are ignored
        instr(8'hAC, 8'h53, 8'h00, 8'h00, "R10 enable while held");
        set_hold(1'b0);

        // R3: gating before enable
        instr(8'h20, 8'h00, 8'h05, 8'h3C, "R3 read before enable");
        instr(8'h40, 8'h00, 8'h07, 8'h11, "R3 write before enable");
        instr(8'hAC, 8'h12, 8'h34, 8'h56, "R3 wrong key");
        instr(8'hAC, 8'h53, 8'h00, 8'h00, "R3 enable key");
        instr(8'h20, 8'h00, 8'h07, 8'h00, "R3 earlier write ignored");
        instr(8'h20, 8'h00, 8'h05, 8'h00, "R1 blank program byte");

        // R5 R6: program memory
        instr(8'h40, 8'h00, 8'h05, 8'h3C, "R6 write program");
        instr(8'h20, 8'h00, 8'h05, 8'h00, "R5 read program");
        instr(8'h40, 8'h12, 8'h49, 8'hA5, "R6 write wrapped address");
        instr(8'h20, 8'h00, 8'h09, 8'h00, "R5 read wrapped address");

        // R7 R8: data memory and polling
        instr(8'hC0, 8'h00, 8'h03, 8'h5A, "R7 write data");
        instr(8'hA0, 8'h00, 8'h03, 8'h00, "R8 poll erase phase");
        instr(8'hA0, 8'h00, 8'h04, 8'h00, "R8 other address");
        instr(8'hA0, 8'h00, 8'h03, 8'h00, "R8 poll program phase");
        repeat (1200) @(negedge clk);
        instr(8'hA0, 8'h00, 8'h03, 8'h00, "R7 read after window");

        // R9: chip erase
        instr(8'hAC, 8'h80, 8'h00, 8'h00, "R9 chip erase");
        instr(8'h20, 8'h00, 8'h05, 8'h00, "R9 program blank");
        instr(8'hA0, 8'h00, 8'h03, 8'h00, "R9 data blank");

        // R10: partial byte, then hold release resynchronises and disables
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            sck  = 1'b0;
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sck = 1'b0;
        set_hold(1'b1);
        check("R10 miso low while held", miso, 0);
        set_hold(1'b0);
        instr(8'h20, 8'h00, 8'h05, 8'h77, "R10 disabled after hold");
        instr(8'hAC, 8'h53, 8'h00, 8'h00, "R10 re-enable");
        instr(8'h40, 8'h00, 8'h05, 8'h99, "R6 write after re-enable");
        instr(8'h20, 8'h00, 8'h05, 8'h00, "R5 read after re-enable");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule